// File: doc/BRIEF.md
# Banked Video RAM Window Controller

This block lets an 8-bit CPU reach a video RAM larger than its address window. A fixed range of the CPU address space is split into two equal halves, and each half has its own page register. A CPU access inside the window picks the page register of its half, and the stored page number is placed above the in-page offset to form the physical RAM address. Because the halves page independently, two different pages of video RAM can be visible to the CPU at once. This makes copies between pages possible without rewriting a page register in between.

The two page registers sit at a pair of CPU addresses outside the window and can be read back. The RAM is byte wide and held inside the block. A second, read-only port with its own full physical address serves a video fetch engine. Both read paths return data one cycle after the request. The page offset width is `PAGE_W`: 12 gives 4 KB pages, a window of 0xC000 to 0xDFFF and 64 KB of RAM with 4-bit page registers. The default of 8 keeps the stored array small for elaboration.

Top module: `vwin_ctrl`

## Requirements
- R1: A CPU access whose address lies in WIN_BASE to WIN_BASE + 2*2^PAGE_W - 1 (default 0xC000 to 0xC1FF) reaches the video RAM; no other address does.
- R2: Within the window, CPU address bit PAGE_W chooses the page register (0 selects the register at BANK_BASE, 1 the one at BANK_BASE+1), and bits PAGE_W-1:0 give the in-page offset.
- R3: The physical RAM address is the selected page value shifted left by PAGE_W, ORed with the offset.
- R4: A CPU write to BANK_BASE or BANK_BASE+1 (default 0xFF00, 0xFF01) loads that page register with the low BANK_W bits of the write data, and the upper data bits are dropped. Without such a write, a page register holds its value.
- R5: A CPU read of a page register returns its value in bits BANK_W-1:0, with all higher bits zero.
- R6: After reset both page registers are 0.
- R7: CPU read data is valid on cpu_rdata in the cycle after the cycle in which cpu_rd is sampled high, and it holds until the next read.
- R8: A CPU read of an address that is neither in the window nor a page register returns 0. A CPU write to such an address changes no RAM byte and no page register.
- R9: The video port returns the RAM byte at vid_addr one cycle after vid_addr is presented.
- R10: When a CPU write hits the same physical address that the video port reads in that cycle, the video port returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe (wins when both strobes are high) |
| cpu_rdata | output | DATA_W | CPU read data, one cycle after cpu_rd |
| vid_addr | input | BANK_W+PAGE_W | Video fetch physical address |
| vid_data | output | DATA_W | Video fetch data, one cycle after vid_addr |

## Verification
The bench fills every page through one half of the window and reads the whole RAM back through the video port. A wrong shift or OR in the physical address would scatter or alias the bytes, and that would show in the readback. It then pages two different values into the halves and reads both halves. A design that used the wrong address bit to pick a register, or that shared one register, would return bytes of the wrong page. The bench also covers writes with the upper data bits set to a page register, and reads and writes just outside both edges of the window; a missing mask or a loose window compare would corrupt RAM or return nonzero data. Last, it drives a CPU write and a video read at the same address in one cycle, where a design without forwarding returns the stale byte.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

    // Which resource a CPU address lands on
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_VRAM = 2'd1,
        TGT_BANK = 2'd2
    } tgt_e;

endpackage

// File: rtl/vwin_decode.sv
module vwin_decode
    import vwin_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hC000,
    parameter logic [ADDR_W-1:0] BANK_BASE = 16'hFF00
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic              half,
    output logic [PAGE_W-1:0] offset,
    output logic              reg_sel
);
    localparam logic [31:0] WIN_LO = 32'(WIN_BASE);
    localparam logic [31:0] WIN_HI = 32'(WIN_BASE) + (32'd2 << PAGE_W) - 32'd1;

    logic [31:0] addr_ext;
    logic        in_win;
    logic        in_bank;

    always_comb begin
        addr_ext = 32'(addr);
        in_win   = (addr_ext >= WIN_LO) && (addr_ext <= WIN_HI);
        in_bank  = (addr[ADDR_W-1:1] == BANK_BASE[ADDR_W-1:1]);
        if (in_win)       tgt = TGT_VRAM;
        else if (in_bank) tgt = TGT_BANK;
        else              tgt = TGT_NONE;
        half    = addr[PAGE_W];
        offset  = addr[PAGE_W-1:0];
        reg_sel = addr[0];
    end
endmodule

// File: rtl/vwin_bank_regs.sv
module vwin_bank_regs #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 4,
    parameter int NREG   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(NREG)-1:0]    sel,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NREG-1:0][BANK_W-1:0] bank
);
    typedef struct packed {
        logic [NREG-1:0][BANK_W-1:0] page;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (we && (int'(sel) == i)) st_d.page[i] = wdata[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.page;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank)); // R4
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> bank[$past(sel)] == $past(wdata[BANK_W-1:0])); // R4
endmodule

// File: rtl/vwin_ram.sv
module vwin_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic          cpu_re,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_q,
    input  logic [AW-1:0] vid_addr,
    output logic [DW-1:0] vid_q
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] cpu;
        logic [DW-1:0] vid;
    } port_st_t;

    logic [DW-1:0] mem_q [DEPTH];
    port_st_t      st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_re) st_d.cpu = mem_q[cpu_addr];
        if (cpu_we && (cpu_addr == vid_addr)) st_d.vid = cpu_wdata;
        else                                   st_d.vid = mem_q[vid_addr];
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (cpu_we) mem_q[cpu_addr] <= cpu_wdata;
    end

    assign cpu_q = st_q.cpu;
    assign vid_q = st_q.vid;

    AST_VID_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == vid_addr) |=> vid_q == $past(cpu_wdata)); // R10
    AST_CPU_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_re && $past(cpu_re)) |=> $stable(cpu_q)); // R7
endmodule

// File: rtl/vwin_ctrl.sv
module vwin_ctrl
    import vwin_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8,
    parameter int BANK_W = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hC000,
    parameter logic [ADDR_W-1:0] BANK_BASE = 16'hFF00,
    localparam int PHYS_W = BANK_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [PHYS_W-1:0] vid_addr,
    output logic [DATA_W-1:0] vid_data
);
    localparam int NREG = 2;

    typedef struct packed {
        tgt_e              src;
        logic [DATA_W-1:0] regval;
    } rd_st_t;

    tgt_e                        tgt;
    logic                        half;
    logic [PAGE_W-1:0]           offset;
    logic                        reg_sel;
    logic [NREG-1:0][BANK_W-1:0] bank;
    logic [PHYS_W-1:0]           phys;
    logic                        rd_go;
    logic [DATA_W-1:0]           ram_q;
    rd_st_t                      st_d, st_q;

    vwin_decode #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
        .WIN_BASE(WIN_BASE), .BANK_BASE(BANK_BASE)
    ) u_decode (
        .addr(cpu_addr), .tgt(tgt), .half(half),
        .offset(offset), .reg_sel(reg_sel)
    );

    vwin_bank_regs #(.DATA_W(DATA_W), .BANK_W(BANK_W), .NREG(NREG)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .we(cpu_wr && (tgt == TGT_BANK)),
        .sel(reg_sel), .wdata(cpu_wdata), .bank(bank)
    );

    assign phys  = {bank[half], offset};
    assign rd_go = cpu_rd && !cpu_wr;

    vwin_ram #(.AW(PHYS_W), .DW(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_wr && (tgt == TGT_VRAM)),
        .cpu_re(rd_go && (tgt == TGT_VRAM)),
        .cpu_addr(phys), .cpu_wdata(cpu_wdata), .cpu_q(ram_q),
        .vid_addr(vid_addr), .vid_q(vid_data)
    );

    always_comb begin
        st_d = st_q;
        if (rd_go) begin
            st_d.src = tgt;
            if (tgt == TGT_BANK)
                st_d.regval = {{(DATA_W-BANK_W){1'b0}}, bank[reg_sel]};
            else
                st_d.regval = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{src: TGT_NONE, regval: '0};
        else        st_q <= st_d;
    end

    assign cpu_rdata = (st_q.src == TGT_VRAM) ? ram_q : st_q.regval;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && tgt == TGT_NONE) |=> cpu_rdata == '0); // R8
    AST_REG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && tgt == TGT_BANK) |=> cpu_rdata[DATA_W-1:BANK_W] == '0); // R5
    AST_REG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && tgt == TGT_BANK) |=> cpu_rdata[BANK_W-1:0] == bank[$past(reg_sel)]); // R5
    AST_RESET_BANKS: assert property (@(posedge clk)
        !rst_n |=> bank == '0); // R6
endmodule

// File: tb/vwin_ctrl_test.sv
`timescale 1ns/1ps
module vwin_ctrl_test;
    localparam int PAGE_W = 8;
    localparam int BANK_W = 4;
    localparam int PHYS_W = PAGE_W + BANK_W;
    localparam int PAGES  = 1 << BANK_W;
    localparam int PSIZE  = 1 << PAGE_W;
    localparam int DEPTH  = 1 << PHYS_W;
    localparam int WBASE  = 'hC000;
    localparam int BBASE  = 'hFF00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_rd = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [7:0]        cpu_rdata;
    logic [PHYS_W-1:0] vid_addr = '0;
    logic [7:0]        vid_data;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    int   bk [2];
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    vwin_ctrl #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .vid_addr(vid_addr), .vid_data(vid_data)
    );

    function automatic logic [7:0] pat(int p, int o, int salt);
        return 8'((p * 37 + o * 5 + salt) & 255);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(int a, int d);
        @(negedge clk);
        cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a >= WBASE && a < WBASE + 2 * PSIZE)
            model[bk[(a >> PAGE_W) & 1] * PSIZE + (a & (PSIZE - 1))] = 8'(d);
        else if (a == BBASE || a == BBASE + 1)
            bk[a & 1] = d & (PAGES - 1);
    endtask

    task automatic cpu_read(int a, output int d);
        @(negedge clk);
        cpu_addr = 16'(a); cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = int'(cpu_rdata);
    endtask

    task automatic vid_sweep(string req);
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            vid_addr = PHYS_W'(i);
            @(negedge clk);
            if (vid_data !== model[i]) begin
                if (bad == 0) check(req, int'(vid_data), int'(model[i]));
                bad++;
            end
        end
        if (bad == 0) check(req, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        bk[0] = 0; bk[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 and R5: both page registers clear after reset
        cpu_read(BBASE, r);     check("R6 page reg 0 reset", r, 0);
        cpu_read(BBASE + 1, r); check("R6 page reg 1 reset", r, 0);

        // R1 R3: fill every page through the lower half
        for (int p = 0; p < PAGES; p++) begin
            cpu_write(BBASE, p);
            for (int o = 0; o < PSIZE; o++) cpu_write(WBASE + o, pat(p, o, 3));
        end
        // R9: whole RAM through the video port
        vid_sweep("R9 R3 video readback after fill");

        // R2 R7: two different pages in the two halves
        for (int k = 0; k < 4; k++) begin
            int a0 = (k * 5 + 1) % PAGES;
            int a1 = (k * 7 + 9) % PAGES;
            int bad = 0;
            cpu_write(BBASE, a0);
            cpu_write(BBASE + 1, a1);
            for (int o = 0; o < PSIZE; o += 17) begin
                cpu_read(WBASE + o, r);
                if (r != int'(pat(a0, o, 3))) begin bad++; check("R2 R7 lower half", r, int'(pat(a0, o, 3))); end
                cpu_read(WBASE + PSIZE + o, r);
                if (r != int'(pat(a1, o, 3))) begin bad++; check("R2 R7 upper half", r, int'(pat(a1, o, 3))); end
            end
            if (bad == 0) check("R2 R7 split pages", 0, 0);
        end

        // R7: read data holds until the next read
        cpu_read(WBASE + 4, r);
        repeat (3) @(negedge clk);
        check("R7 read data holds", int'(cpu_rdata), r);

        // R2 R3: writes through the upper half land in its page
        cpu_write(BBASE + 1, 5);
        for (int o = 0; o < PSIZE; o++) cpu_write(WBASE + PSIZE + o, pat(5, o, 91));
        vid_sweep("R2 R3 upper-half writes");

        // R4 R5: upper data bits dropped, readback zero-extended
        cpu_write(BBASE, 'hA7);
        cpu_read(BBASE, r);     check("R4 R5 page reg 0 mask", r, 'h07);
        cpu_write(BBASE + 1, 'hFC);
        cpu_read(BBASE + 1, r); check("R4 R5 page reg 1 mask", r, 'h0C);
        cpu_read(WBASE + 2, r); check("R4 masked page used", r, int'(model[7 * PSIZE + 2]));

        // R8 and R1: reads just outside the window and elsewhere
        cpu_read(WBASE - 1, r);         check("R8 R1 below window", r, 0);
        cpu_read(WBASE + 2 * PSIZE, r); check("R8 R1 above window", r, 0);
        cpu_read('hFE00, r);            check("R8 unmapped high", r, 0);
        cpu_read(BBASE + 2, r);         check("R8 next to page regs", r, 0);
        // R8: writes outside change nothing
        cpu_write(WBASE - 1, 'h55);
        cpu_write(WBASE + 2 * PSIZE, 'h66);
        cpu_write(BBASE + 2, 'h03);
        cpu_write(0, 'h77);
        cpu_read(BBASE, r);     check("R8 page reg 0 untouched", r, 7);
        cpu_read(BBASE + 1, r); check("R8 page reg 1 untouched", r, 'hC);
        vid_sweep("R8 RAM untouched by unmapped writes");

        // R10: CPU write and video read at the same physical address
        for (int k = 0; k < 4; k++) begin
            int o = k * 29 + 3;
            @(negedge clk);
            cpu_addr = 16'(WBASE + o); cpu_wdata = pat(k, o, 200); cpu_wr = 1'b1;
            vid_addr = PHYS_W'(7 * PSIZE + o);
            @(negedge clk);
            cpu_wr = 1'b0;
            model[7 * PSIZE + o] = pat(k, o, 200);
            check("R10 video sees same-cycle write", int'(vid_data), int'(pat(k, o, 200)));
            @(negedge clk);
            check("R9 R10 stored byte", int'(vid_data), int'(pat(k, o, 200)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule